// File: doc/BRIEF.md
# Half-Rate Two-Tap Decision Feedback Equaliser

This block cancels the first two post-cursors of inter-symbol interference on a received data stream. The stream arrives as two consecutive signed samples per clock. The earlier sample is the even bit and the later one is the odd bit, as a half-rate receiver would see them from two samplers clocked on opposite edges. Each lane subtracts a first-tap term and a second-tap term from its own sample and then slices the corrected value to one bit. Each term is a signed coefficient multiplied by the polarity of an earlier decision.

The feedback crosses between the lanes. For an even bit, the immediately preceding bit is the odd decision of the previous cycle, and the bit before that is the even decision of the previous cycle. For an odd bit, the immediately preceding bit is the even decision made in the same cycle, and the bit before that is the odd decision of the previous cycle. Read in even-then-odd order, the two decision outputs therefore form the same bit stream that a serial full-rate two-tap equaliser would produce from the same samples. Each lane equalises only its own bit positions.

Top module: `hr_dfe2`

## Requirements
- R1: Each cycle with `in_vld` high produces one even decision, in `dec_even`, and one odd decision, in `dec_odd`, from that cycle's samples. Both decisions appear one clock later, together with `out_vld` high.
- R2: The even lane computes `smp_even - coef1*p(previous-cycle dec_odd) - coef2*p(previous-cycle dec_even)`.
- R3: The odd lane computes `smp_odd - coef1*p(same-cycle even decision) - coef2*p(previous-cycle dec_odd)`.
- R4: In R2 and R3, p(1) = +1 and p(0) = -1. A slicer outputs 1 when its corrected value is greater than or equal to zero, so a value of exactly zero gives 1, and outputs 0 otherwise.
- R5: In a cycle with `in_vld` low, the samples and coefficients have no effect. `out_vld` is low one clock later, both decision outputs keep their values, and the feedback history is kept for the next valid cycle.
- R6: A synchronous active-high `rst` clears both decisions and `out_vld` to 0 at the next clock. The cleared history then counts as two -1 decisions.
- R7: Concatenated in even-then-odd order, the sequence of valid decision pairs equals the output of a serial two-tap decision feedback equaliser fed the same sample sequence.
- R8: The corrected sums never overflow. Full-scale negative and positive samples and coefficients are sliced correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Half-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Sample pair valid strobe |
| smp_even | input | SAMPLE_W | Signed sample of the earlier (even) bit |
| smp_odd | input | SAMPLE_W | Signed sample of the later (odd) bit |
| coef1 | input | COEF_W | Signed first post-cursor coefficient |
| coef2 | input | COEF_W | Signed second post-cursor coefficient |
| out_vld | output | 1 | Decision pair valid, one cycle after `in_vld` |
| dec_even | output | 1 | Registered even-lane decision |
| dec_odd | output | 1 | Registered odd-lane decision |

## Verification
Every result is due exactly one clock after the cycle in which its samples are presented. This applies to both decisions, to `out_vld` and to the cleared state after `rst`. The bench drives inputs on the falling edge, lets the next rising edge register them and compares all three outputs at the following falling edge. It compares them against a serial two-tap model that advances its two-bit history only on valid cycles. The hold behaviour is checked at the same sampling point: the outputs must stay unchanged during idle cycles, and the first valid pair after an idle stretch must still match the model's preserved history.

// File: rtl/hr_dfe2_pkg.sv
package hr_dfe2_pkg;

  typedef enum logic {
    LANE_EVEN = 1'b0,
    LANE_ODD  = 1'b1
  } lane_e;

  // Width that holds sample - coef - coef without overflow.
  function automatic int sum_width(input int samp_w, input int coef_w);
    int widest;
    widest = (samp_w > coef_w) ? samp_w : coef_w;
    return widest + 2;
  endfunction

endpackage

// File: rtl/hr_dfe2_tap.sv
module hr_dfe2_tap #(
  parameter int COEF_W = 8,
  parameter int SUM_W  = 10
) (
  input  logic [COEF_W-1:0] coef,
  input  logic              fb_bit,
  output logic [SUM_W-1:0]  term
);

  logic [SUM_W-1:0] coef_x;

  assign coef_x = {{(SUM_W-COEF_W){coef[COEF_W-1]}}, coef};

  // A decision of 1 weighs +1, a decision of 0 weighs -1.
  always_comb begin
    if (fb_bit) term = coef_x;
    else        term = (~coef_x) + SUM_W'(1);
  end

endmodule

// File: rtl/hr_dfe2_lane.sv
module hr_dfe2_lane
  import hr_dfe2_pkg::*;
#(
  parameter int    SAMPLE_W = 8,
  parameter int    COEF_W   = 8,
  parameter lane_e LANE     = LANE_EVEN
) (
  input  logic [SAMPLE_W-1:0] sample,
  input  logic [COEF_W-1:0]   coef1,
  input  logic [COEF_W-1:0]   coef2,
  input  logic                fb_near,
  input  logic                fb_far,
  output logic                decision
);

  localparam int SUM_W = sum_width(SAMPLE_W, COEF_W);

  logic [SUM_W-1:0] samp_x;
  logic [SUM_W-1:0] term_near;
  logic [SUM_W-1:0] term_far;
  logic [SUM_W-1:0] corrected;

  assign samp_x = {{(SUM_W-SAMPLE_W){sample[SAMPLE_W-1]}}, sample};

  hr_dfe2_tap #(.COEF_W(COEF_W), .SUM_W(SUM_W)) u_tap_near (
    .coef   (coef1),
    .fb_bit (fb_near),
    .term   (term_near)
  );

  hr_dfe2_tap #(.COEF_W(COEF_W), .SUM_W(SUM_W)) u_tap_far (
    .coef   (coef2),
    .fb_bit (fb_far),
    .term   (term_far)
  );

  assign corrected = samp_x - term_near - term_far;

  // Slice at zero: non-negative gives 1.
  generate
    if (LANE == LANE_EVEN) begin : g_even
      assign decision = ~corrected[SUM_W-1];
    end else begin : g_odd
      assign decision = ~corrected[SUM_W-1];
    end
  endgenerate

endmodule

// File: rtl/hr_dfe2.sv
module hr_dfe2
  import hr_dfe2_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int COEF_W   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_vld,
  input  logic [SAMPLE_W-1:0] smp_even,
  input  logic [SAMPLE_W-1:0] smp_odd,
  input  logic [COEF_W-1:0]   coef1,
  input  logic [COEF_W-1:0]   coef2,
  output logic                out_vld,
  output logic                dec_even,
  output logic                dec_odd
);

  logic even_now;
  logic odd_now;
  logic even_q;
  logic odd_q;
  logic vld_q;

  // Even bit: nearest earlier bit is last cycle's odd, next is last even.
  hr_dfe2_lane #(
    .SAMPLE_W (SAMPLE_W),
    .COEF_W   (COEF_W),
    .LANE     (LANE_EVEN)
  ) u_lane_even (
    .sample   (smp_even),
    .coef1    (coef1),
    .coef2    (coef2),
    .fb_near  (odd_q),
    .fb_far   (even_q),
    .decision (even_now)
  );

  // Odd bit: nearest earlier bit is this cycle's even, next is last odd.
  hr_dfe2_lane #(
    .SAMPLE_W (SAMPLE_W),
    .COEF_W   (COEF_W),
    .LANE     (LANE_ODD)
  ) u_lane_odd (
    .sample   (smp_odd),
    .coef1    (coef1),
    .coef2    (coef2),
    .fb_near  (even_now),
    .fb_far   (odd_q),
    .decision (odd_now)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      even_q <= 1'b0;
      odd_q  <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= in_vld;
      if (in_vld) begin
        even_q <= even_now;
        odd_q  <= odd_now;
      end
    end
  end

  assign out_vld  = vld_q;
  assign dec_even = even_q;
  assign dec_odd  = odd_q;

endmodule

// File: rtl/hr_dfe2_chk.sv
module hr_dfe2_chk #(
  parameter int SAMPLE_W = 8,
  parameter int COEF_W   = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                in_vld,
  input logic [SAMPLE_W-1:0] smp_even,
  input logic [SAMPLE_W-1:0] smp_odd,
  input logic [COEF_W-1:0]   coef1,
  input logic [COEF_W-1:0]   coef2,
  input logic                out_vld,
  input logic                dec_even,
  input logic                dec_odd
);

  function automatic int pol(input logic b);
    return b ? 1 : -1;
  endfunction

  int   y_even;
  int   y_odd;
  logic want_even;
  logic want_odd;

  always_comb begin
    y_even    = int'($signed(smp_even)) - int'($signed(coef1)) * pol(dec_odd)
              - int'($signed(coef2)) * pol(dec_even);
    want_even = (y_even >= 0);
    y_odd     = int'($signed(smp_odd)) - int'($signed(coef1)) * pol(want_even)
              - int'($signed(coef2)) * pol(dec_odd);
    want_odd  = (y_odd >= 0);
  end

  AST_EVEN_DECISION: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> (dec_even == $past(want_even))); // R2

  AST_ODD_DECISION: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> (dec_odd == $past(want_odd))); // R3

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> out_vld); // R1

  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> !out_vld); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> ($stable(dec_even) && $stable(dec_odd))); // R5

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!out_vld && !dec_even && !dec_odd)); // R6

endmodule

bind hr_dfe2 hr_dfe2_chk #(.SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W)) u_chk (.*);

// File: tb/hr_dfe2_test.sv
`timescale 1ns/1ps
module hr_dfe2_test;

  localparam int SW = 8;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_vld = 1'b0;
  logic [SW-1:0] smp_even = '0;
  logic [SW-1:0] smp_odd = '0;
  logic [CW-1:0] coef1 = '0;
  logic [CW-1:0] coef2 = '0;
  logic          out_vld;
  logic          dec_even;
  logic          dec_odd;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // Serial model state: h1 = most recent bit, h2 = the one before.
  logic m_h1 = 1'b0;
  logic m_h2 = 1'b0;
  logic x_even = 1'b0;
  logic x_odd  = 1'b0;

  always #4 clk = ~clk;

  hr_dfe2 #(.SAMPLE_W(SW), .COEF_W(CW)) uut (
    .clk(clk), .rst(rst), .in_vld(in_vld),
    .smp_even(smp_even), .smp_odd(smp_odd),
    .coef1(coef1), .coef2(coef2),
    .out_vld(out_vld), .dec_even(dec_even), .dec_odd(dec_odd)
  );

  function automatic int pol(input logic b);
    return b ? 1 : -1;
  endfunction

  function automatic logic serial_bit(input int s, input int c1, input int c2,
                                      input logic h1, input logic h2);
    return (s - c1 * pol(h1) - c2 * pol(h2)) >= 0;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_outs(input string req, input logic exp_vld);
    chk(out_vld == exp_vld, req, "out_vld", int'(out_vld), int'(exp_vld));
    chk(dec_even == x_even, req, "dec_even", int'(dec_even), int'(x_even));
    chk(dec_odd == x_odd, req, "dec_odd", int'(dec_odd), int'(x_odd));
  endtask

  // Called at a falling edge; checks at the next falling edge.
  task automatic step(input logic v, input int se, input int so,
                      input int c1, input int c2, input string req);
    in_vld   = v;
    smp_even = SW'(se);
    smp_odd  = SW'(so);
    coef1    = CW'(c1);
    coef2    = CW'(c2);
    if (v) begin
      x_even = serial_bit(se, c1, c2, m_h1, m_h2);
      m_h2   = m_h1;
      m_h1   = x_even;
      x_odd  = serial_bit(so, c1, c2, m_h1, m_h2);
      m_h2   = m_h1;
      m_h1   = x_odd;
    end
    @(negedge clk);
    check_outs(req, v);
  endtask

  task automatic do_reset(input int cycles);
    rst    = 1'b1;
    in_vld = 1'b1;
    smp_even = 8'd100;
    smp_odd  = 8'd100;
    repeat (cycles) @(negedge clk);
    m_h1 = 1'b0; m_h2 = 1'b0; x_even = 1'b0; x_odd = 1'b0;
    check_outs("R6", 1'b0);
    rst    = 1'b0;
    in_vld = 1'b0;
  endtask

  function automatic int rsamp();
    return int'($signed(SW'($urandom_range(0, (1 << SW) - 1))));
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    do_reset(3);

    // R4: slicer threshold at exactly zero, history -1,-1 after reset.
    step(1'b1, -8, 2, 5, 3, "R4");
    step(1'b1, 0, 0, 0, 0, "R4");
    step(1'b1, -1, -1, 0, 0, "R4");

    // R2: first tap only, even lane uses previous odd decision.
    for (int i = 0; i < 40; i++)
      step(1'b1, rsamp() / 4, rsamp() / 4, 60, 0, "R2");
    // R3: second tap only, odd lane uses previous odd decision.
    for (int i = 0; i < 40; i++)
      step(1'b1, rsamp() / 4, rsamp() / 4, 0, -50, "R3");

    // R5: idle cycles keep outputs and history.
    step(1'b1, 20, -20, 30, 10, "R5");
    for (int i = 0; i < 6; i++)
      step(1'b0, rsamp(), rsamp(), rsamp(), rsamp(), "R5");
    step(1'b1, 25, -25, 30, 10, "R5");

    // R1 and R7: random samples and coefficients, interleaved idles.
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(0, 7) == 0)
        step(1'b0, rsamp(), rsamp(), rsamp(), rsamp(), "R1");
      else
        step(1'b1, rsamp(), rsamp(), rsamp() / 2, rsamp() / 2, "R7");
    end

    // R8: full-scale extremes.
    step(1'b1, -128, -128, -128, -128, "R8");
    step(1'b1, 127, 127, 127, 127, "R8");
    step(1'b1, -128, 127, 127, -128, "R8");
    step(1'b1, -128, -128, -128, 127, "R8");
    for (int i = 0; i < 60; i++)
      step(1'b1, rsamp(), rsamp(), ($urandom_range(0, 1) != 0) ? -128 : 127,
           ($urandom_range(0, 1) != 0) ? -128 : 127, "R8");

    // R6: reset in mid-stream, then the stream restarts from -1,-1.
    step(1'b1, 50, 50, 10, 10, "R7");
    do_reset(1);
    for (int i = 0; i < 40; i++)
      step(1'b1, rsamp(), rsamp(), rsamp() / 2, rsamp() / 2, "R6");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule